// File: doc/BRIEF.md
# Snoop Filter Directory with Snoop Classification

This block is a set-associative directory that remembers which of up to eight fully coherent requesters may hold a copy of each 64-byte line. When a coherent request arrives, it looks up the line and reports how the line must be snooped. If no other requester holds the line, it reports no snoop. If exactly one does, it reports a directed snoop. If several do, it reports a multicast. If every other requester holds the line, it reports a broadcast. It also gives the bitmask of the requesters to be snooped. The aim is to send targeted snoops wherever the tracked state allows, so that snoop and response traffic stays low.

Requesters report the lines they gain and lose through a separate update port (allocate or deallocate). When an allocation misses in a full set, a pseudo-random way is replaced. Every holder recorded in the displaced entry must then drop its copy, so the block emits a back-invalidate snoop for that entry on the same output. Each request or update is taken in one cycle. The result is registered and appears on the following cycle. Moving the snoops, collecting their responses and storing line data are left to the surrounding logic.

Top module: `snoop_filter_dir`

## Requirements
- R1: After reset, `out_valid` and `out_evict` are 0 and the directory is empty, so any lookup reports no snoop.
- R2: Lines are tracked per 64-byte block. Address bits [5:0] are ignored, bits [11:6] select one of 64 sets, and bits [31:12] form the tag that must match.
- R3: A request (`req_valid`=1) produces exactly one response cycle on the next clock, with `out_valid`=1 and `out_evict`=0. With no new input, `out_valid` returns to 0 on the cycle after that.
- R4: A request that misses, or that finds only the requester's own bit, reports kind 0 (none) with an all-zero mask. The requester's own bit is never set in a request's mask.
- R5: When exactly one other requester holds the line, the block reports kind 1 (directed) and a one-hot mask naming that holder.
- R6: When two or more other requesters hold the line, but not all of them, the block reports kind 2 (multicast) and a mask of exactly those holders.
- R7: When all seven other requesters hold the line, the block reports kind 3 (broadcast) and a mask of every requester except the one asking.
- R8: A request with `req_inv`=1 that finds other holders leaves only the requester's bit in the entry. If the requester did not hold the line, the entry is freed. A request with `req_inv`=0 changes nothing.
- R9: An allocate update sets the bit of `upd_id` in the line's entry, creating the entry if needed. A deallocate clears only that bit, and clearing the last bit frees the entry. Updates give no output unless they evict.
- R10: Each set holds 16 lines. An allocate that misses uses a free way if one exists, and this causes no eviction and no output.
- R11: An allocate that misses in a full set replaces a way chosen by a 16-bit LFSR. On the next cycle it outputs `out_valid`=1 and `out_evict`=1, with the displaced entry's presence vector as the mask. The kind is directed for one holder, broadcast for all eight, and multicast otherwise. The displaced line is no longer tracked.
- R12: When a request and an update arrive in the same cycle, the request is served and the update is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Coherent request present |
| req_addr | input | 32 | Physical address of the request |
| req_id | input | 3 | Requester number |
| req_inv | input | 1 | Request invalidates other copies |
| upd_valid | input | 1 | Presence update present |
| upd_alloc | input | 1 | 1 = allocate, 0 = deallocate |
| upd_addr | input | 32 | Physical address of the update |
| upd_id | input | 3 | Requester being updated |
| out_valid | output | 1 | Snoop decision valid |
| out_evict | output | 1 | Decision is a back-invalidate for an evicted entry |
| out_kind | output | 2 | 0 none, 1 directed, 2 multicast, 3 broadcast |
| out_mask | output | 8 | Requesters to snoop |

## Verification
The bench builds presence vectors with zero, one, several and all other holders. This separates the four snoop kinds, and each case asks from both a holder and a non-holder so that exclusion of the requester is exposed. Addresses that differ only in the offset, only in the tag or only in the set show whether the index and tag fields are decoded correctly. One set is filled with sixteen lines that each carry a distinct presence pattern, so the eviction mask identifies the replaced way. Later lookups then show that only that line was lost and that a freed way is reused without displacing anything. Invalidating lookups, deallocations by holders and by non-holders, and a collision between a request and an update test the state changes.

// File: rtl/snpdir_pkg.sv
package snpdir_pkg;

    typedef enum logic [1:0] {
        SNP_NONE     = 2'd0,
        SNP_DIRECTED = 2'd1,
        SNP_MULTI    = 2'd2,
        SNP_BCAST    = 2'd3
    } snp_kind_e;

endpackage

// File: rtl/snpdir_lfsr.sv
module snpdir_lfsr #(
    parameter logic [15:0] SEED  = 16'hACE1,
    parameter int          OUT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] pick
);

    logic [15:0] state_d, state_q;

    always_comb begin
        state_d = {state_q[14:0], state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= state_d;
    end

    assign pick = state_q[OUT_W-1:0];

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 16'd0); // R11

endmodule

// File: rtl/snpdir_classify.sv
module snpdir_classify
    import snpdir_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] holders,
    input  logic [N-1:0] eligible,
    output snp_kind_e    kind
);

    localparam int CNT_W = $clog2(N + 1);

    logic [CNT_W-1:0] cnt;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++) cnt = cnt + CNT_W'(holders[i]);
        if (cnt == '0)                          kind = SNP_NONE;
        else if (cnt == CNT_W'(1))              kind = SNP_DIRECTED;
        else if ((holders & eligible) == eligible) kind = SNP_BCAST;
        else                                    kind = SNP_MULTI;
    end

endmodule

// File: rtl/snoop_filter_dir.sv
module snoop_filter_dir
    import snpdir_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          NUM_REQ    = 8,
    parameter int          NUM_SETS   = 64,
    parameter int          NUM_WAYS   = 16,
    parameter int          LINE_BYTES = 64,
    parameter logic [15:0] LFSR_SEED  = 16'hACE1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [$clog2(NUM_REQ)-1:0] req_id,
    input  logic                       req_inv,
    input  logic                       upd_valid,
    input  logic                       upd_alloc,
    input  logic [ADDR_W-1:0]          upd_addr,
    input  logic [$clog2(NUM_REQ)-1:0] upd_id,
    output logic                       out_valid,
    output logic                       out_evict,
    output logic [1:0]                 out_kind,
    output logic [NUM_REQ-1:0]         out_mask
);

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(NUM_SETS);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam int WAY_W = $clog2(NUM_WAYS);
    localparam int ID_W  = $clog2(NUM_REQ);

    typedef struct packed {
        logic               vld;
        logic [TAG_W-1:0]   tag;
        logic [NUM_REQ-1:0] pv;
    } dir_ent_t;

    typedef struct packed {
        logic               vld;
        logic               evict;
        logic [1:0]         kind;
        logic [NUM_REQ-1:0] mask;
    } out_t;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic [WAY_W-1:0] way;
        dir_ent_t         ent;
    } wr_t;

    dir_ent_t dir_q [NUM_SETS][NUM_WAYS];
    out_t     out_d, out_q;
    wr_t      wr_d;

    // lookup address selection: a request always wins the single port
    logic [ADDR_W-1:0]  look_addr;
    logic [ID_W-1:0]    look_id;
    logic [IDX_W-1:0]   look_idx;
    logic [TAG_W-1:0]   look_tag;
    logic [NUM_REQ-1:0] id_bit;

    always_comb begin
        look_addr = req_valid ? req_addr : upd_addr;
        look_id   = req_valid ? req_id   : upd_id;
        look_idx  = look_addr[OFF_W +: IDX_W];
        look_tag  = look_addr[ADDR_W-1 -: TAG_W];
        id_bit    = NUM_REQ'(1) << look_id;
    end

    // per-way compare
    logic [NUM_WAYS-1:0] hit_vec, free_vec;

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
        assign hit_vec[g]  = dir_q[look_idx][g].vld && (dir_q[look_idx][g].tag == look_tag);
        assign free_vec[g] = !dir_q[look_idx][g].vld;
    end

    logic             hit, free_any;
    logic [WAY_W-1:0] hit_way, free_way, vic_way;
    dir_ent_t         hit_ent, vic_ent;

    always_comb begin
        hit      = |hit_vec;
        free_any = |free_vec;
        hit_way  = '0;
        free_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w])  hit_way  = WAY_W'(w);
            if (free_vec[w]) free_way = WAY_W'(w);
        end
    end

    snpdir_lfsr #(
        .SEED  (LFSR_SEED),
        .OUT_W (WAY_W)
    ) u_victim (
        .clk   (clk),
        .rst_n (rst_n),
        .pick  (vic_way)
    );

    assign hit_ent = dir_q[look_idx][hit_way];
    assign vic_ent = dir_q[look_idx][vic_way];

    // classification of either the other holders or the displaced entry
    logic [NUM_REQ-1:0] cls_holders, cls_elig;
    snp_kind_e          cls_kind;

    always_comb begin
        if (req_valid) begin
            cls_holders = hit ? (hit_ent.pv & ~id_bit) : '0;
            cls_elig    = ~id_bit;
        end else begin
            cls_holders = vic_ent.pv;
            cls_elig    = '1;
        end
    end

    snpdir_classify #(
        .N (NUM_REQ)
    ) u_classify (
        .holders  (cls_holders),
        .eligible (cls_elig),
        .kind     (cls_kind)
    );

    // next-state computation
    always_comb begin
        out_d      = '0;
        wr_d       = '0;
        wr_d.idx   = look_idx;
        if (req_valid) begin
            out_d.vld  = 1'b1;
            out_d.kind = cls_kind;
            out_d.mask = cls_holders;
            if (req_inv && hit && (cls_holders != '0)) begin
                wr_d.en     = 1'b1;
                wr_d.way    = hit_way;
                wr_d.ent    = hit_ent;
                wr_d.ent.pv = hit_ent.pv & id_bit;
                wr_d.ent.vld = |(hit_ent.pv & id_bit);
            end
        end else if (upd_valid) begin
            if (upd_alloc) begin
                wr_d.en = 1'b1;
                if (hit) begin
                    wr_d.way    = hit_way;
                    wr_d.ent    = hit_ent;
                    wr_d.ent.pv = hit_ent.pv | id_bit;
                end else begin
                    wr_d.ent = '{vld: 1'b1, tag: look_tag, pv: id_bit};
                    if (free_any) begin
                        wr_d.way = free_way;
                    end else begin
                        wr_d.way    = vic_way;
                        out_d.vld   = 1'b1;
                        out_d.evict = 1'b1;
                        out_d.kind  = cls_kind;
                        out_d.mask  = vic_ent.pv;
                    end
                end
            end else if (hit) begin
                wr_d.en      = 1'b1;
                wr_d.way     = hit_way;
                wr_d.ent     = hit_ent;
                wr_d.ent.pv  = hit_ent.pv & ~id_bit;
                wr_d.ent.vld = |(hit_ent.pv & ~id_bit);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            for (int s = 0; s < NUM_SETS; s++)
                for (int w = 0; w < NUM_WAYS; w++)
                    dir_q[s][w] <= '0;
        end else begin
            out_q <= out_d;
            if (wr_d.en) dir_q[wr_d.idx][wr_d.way] <= wr_d.ent;
        end
    end

    assign out_valid = out_q.vld;
    assign out_evict = out_q.evict;
    assign out_kind  = out_q.kind;
    assign out_mask  = out_q.mask;

    AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid && !out_evict); // R3
    AST_SELF_EXCLUDED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !out_mask[$past(req_id)]); // R4
    AST_NONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_kind == SNP_NONE) |-> out_mask == '0); // R4
    AST_DIRECTED_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_kind == SNP_DIRECTED) |-> $countones(out_mask) == 1); // R5
    AST_MULTI_SEVERAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_kind == SNP_MULTI) |-> $countones(out_mask) > 1); // R6
    AST_DEALLOC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && !upd_alloc && !req_valid |=> !out_valid); // R9
    AST_EVICT_HOLDERS: assert property (@(posedge clk) disable iff (!rst_n)
        out_evict |-> out_valid && (out_mask != '0)); // R11
    AST_REQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && upd_valid |=> !out_evict); // R12

endmodule

// File: tb/snoop_filter_dir_tb.sv
module snoop_filter_dir_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_inv, upd_valid, upd_alloc;
    logic [31:0] req_addr, upd_addr;
    logic [2:0]  req_id, upd_id;
    logic        out_valid, out_evict;
    logic [1:0]  out_kind;
    logic [7:0]  out_mask;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    logic       r_vld, r_ev;
    logic [1:0] r_kind;
    logic [7:0] r_mask;

    always #10 clk = ~clk;

    snoop_filter_dir u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_addr (req_addr), .req_id (req_id), .req_inv (req_inv),
        .upd_valid (upd_valid), .upd_alloc (upd_alloc), .upd_addr (upd_addr), .upd_id (upd_id),
        .out_valid (out_valid), .out_evict (out_evict), .out_kind (out_kind), .out_mask (out_mask)
    );

    function automatic logic [31:0] mk(input int tag, input int set, input int off);
        return (32'(tag) << 12) | (32'(set) << 6) | 32'(off);
    endfunction

    function automatic logic [1:0] exp_kind(input logic [7:0] m, input logic [7:0] elig);
        if (m == 8'h00)                 return 2'd0;
        if ($countones(m) == 1)         return 2'd1;
        if ((m & elig) == elig)         return 2'd3;
        return 2'd2;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic grab();
        @(negedge clk);
        r_vld = out_valid; r_ev = out_evict; r_kind = out_kind; r_mask = out_mask;
        req_valid = 1'b0; upd_valid = 1'b0;
    endtask

    task automatic do_req(input logic [31:0] a, input int id, input logic inv);
        req_valid = 1'b1; req_addr = a; req_id = 3'(id); req_inv = inv;
        grab();
    endtask

    task automatic do_upd(input logic [31:0] a, input int id, input logic alloc);
        upd_valid = 1'b1; upd_addr = a; upd_id = 3'(id); upd_alloc = alloc;
        grab();
    endtask

    // request, then compare {valid, evict, kind, mask}
    task automatic expect_req(input string rq, input logic [31:0] a, input int id,
                              input logic inv, input logic [7:0] m);
        logic [11:0] act, exp;
        logic [7:0] elig;
        elig = ~(8'd1 << id);
        do_req(a, id, inv);
        act = {r_vld, r_ev, r_kind, r_mask};
        exp = {1'b1, 1'b0, exp_kind(m, elig), m};
        chk(act == exp, rq, "request {vld,ev,kind,mask}", int'(act), int'(exp));
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0 && out_evict == 1'b0, "R1", "outputs after reset",
            int'({out_valid, out_evict}), 0);
        expect_req("R1", mk(1, 0, 0), 0, 1'b0, 8'h00);
    endtask

    task automatic t_classes();
        do_upd(mk(16'h11, 1, 6'h3F), 2, 1'b1);
        chk(r_vld == 1'b0, "R9", "alloc output", int'(r_vld), 0);
        expect_req("R2/R5", mk(16'h11, 1, 0), 5, 1'b0, 8'h04);
        expect_req("R4", mk(16'h11, 1, 0), 2, 1'b0, 8'h00);
        @(negedge clk);
        chk(out_valid == 1'b0, "R3", "valid one cycle only", int'(out_valid), 0);
        do_upd(mk(16'h11, 1, 0), 3, 1'b1);
        do_upd(mk(16'h11, 1, 0), 6, 1'b1);
        expect_req("R6", mk(16'h11, 1, 8), 0, 1'b0, 8'h4C);
        expect_req("R2 tag", mk(16'h12, 1, 0), 0, 1'b0, 8'h00);
        expect_req("R2 set", mk(16'h11, 2, 0), 0, 1'b0, 8'h00);
    endtask

    task automatic t_bcast();
        for (int i = 0; i < 8; i++) do_upd(mk(16'h21, 3, 0), i, 1'b1);
        expect_req("R7", mk(16'h21, 3, 0), 4, 1'b0, 8'hEF);
        do_upd(mk(16'h21, 3, 0), 4, 1'b0);
        chk(r_vld == 1'b0, "R9", "dealloc output", int'(r_vld), 0);
        expect_req("R7", mk(16'h21, 3, 0), 4, 1'b0, 8'hEF);
        expect_req("R9/R6", mk(16'h21, 3, 0), 0, 1'b0, 8'hEE);
    endtask

    task automatic t_inv();
        for (int i = 1; i <= 3; i++) do_upd(mk(16'h31, 4, 0), i, 1'b1);
        expect_req("R8", mk(16'h31, 4, 0), 1, 1'b1, 8'h0C);
        expect_req("R8", mk(16'h31, 4, 0), 4, 1'b0, 8'h02);
        expect_req("R8", mk(16'h31, 4, 0), 5, 1'b0, 8'h02);
        expect_req("R8", mk(16'h31, 4, 0), 6, 1'b1, 8'h02);
        expect_req("R8", mk(16'h31, 4, 0), 7, 1'b0, 8'h00);
    endtask

    task automatic t_dealloc();
        do_upd(mk(16'h41, 5, 0), 2, 1'b1);
        do_upd(mk(16'h41, 5, 0), 5, 1'b0);
        expect_req("R9", mk(16'h41, 5, 0), 0, 1'b0, 8'h04);
        do_upd(mk(16'h41, 5, 0), 2, 1'b0);
        expect_req("R9", mk(16'h41, 5, 0), 0, 1'b0, 8'h00);
    endtask

    task automatic t_conflict();
        req_valid = 1'b1; req_addr = mk(16'h51, 6, 0); req_id = 3'd0; req_inv = 1'b0;
        upd_valid = 1'b1; upd_addr = mk(16'h51, 6, 0); upd_id = 3'd3; upd_alloc = 1'b1;
        grab();
        chk({r_vld, r_ev, r_kind, r_mask} == {1'b1, 1'b0, 2'd0, 8'h00}, "R12", "collision response",
            int'({r_vld, r_ev, r_kind, r_mask}), int'({1'b1, 1'b0, 2'd0, 8'h00}));
        expect_req("R12", mk(16'h51, 6, 0), 0, 1'b0, 8'h00);
    endtask

    task automatic t_evict();
        bit          any_out = 0;
        int          victim;
        logic [1:0]  ek;
        for (int k = 0; k < 16; k++)
            for (int b = 0; b < 8; b++)
                if (((k + 1) >> b) & 1) begin
                    do_upd(mk(16'h100 + k, 9, 0), b, 1'b1);
                    if (r_vld) any_out = 1;
                end
        chk(!any_out, "R10", "fill produced output", int'(any_out), 0);
        for (int k = 0; k < 16; k++)
            expect_req("R10", mk(16'h100 + k, 9, 0), 7, 1'b0, 8'(k + 1));
        do_upd(mk(16'h200, 9, 0), 0, 1'b1);
        chk(r_vld && r_ev, "R11", "eviction flags", int'({r_vld, r_ev}), 3);
        chk(r_mask >= 8'd1 && r_mask <= 8'd16, "R11", "victim mask", int'(r_mask), 1);
        ek = exp_kind(r_mask, 8'hFF);
        chk(r_kind == ek, "R11", "eviction kind", int'(r_kind), int'(ek));
        victim = int'(r_mask) - 1;
        if (victim < 0 || victim > 15) victim = 0;
        expect_req("R11", mk(16'h100 + victim, 9, 0), 7, 1'b0, 8'h00);
        expect_req("R11", mk(16'h200, 9, 0), 7, 1'b0, 8'h01);
        do_upd(mk(16'h200, 9, 0), 0, 1'b0);
        do_upd(mk(16'h300, 9, 0), 3, 1'b1);
        chk(r_vld == 1'b0, "R10", "free way reuse output", int'(r_vld), 0);
        expect_req("R10", mk(16'h300, 9, 0), 7, 1'b0, 8'h08);
        for (int k = 0; k < 16; k++)
            if (k != victim)
                expect_req("R10", mk(16'h100 + k, 9, 0), 7, 1'b0, 8'(k + 1));
    endtask

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0; req_inv = 1'b0; req_addr = '0; req_id = '0;
        upd_valid = 1'b0; upd_alloc = 1'b0; upd_addr = '0; upd_id = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_classes();
        t_bcast();
        t_inv();
        t_dealloc();
        t_conflict();
        t_evict();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

endmodule